// File: doc/BRIEF.md
# EEPROM Page Burst Writer

This block is the host-side sequencer that writes one page of a parallel EEPROM in a single burst. A command gives a start address and a byte count of 1 to 128. The block then takes data bytes from a valid/ready stream and, for each byte, drives the address and data pins, lowers chip select, and pulses write enable. The low seven address bits step by one for each byte, and the upper address bits stay fixed for the whole burst. The bytes follow each other closely enough that the device takes them all as one page load.

After the last byte the block waits a fixed programming interval and then reports completion. It does not poll the device. A command whose start offset plus length would run past the end of its 128-byte page is refused. If the byte stream stalls for too long between bytes, the block closes the page load early, waits out the programming interval, and reports an underrun with the completion. Every timing figure is a parameter given in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, ee_we_n, ee_cs_n and ee_oe_n are 1, busy is 0, cmd_ready is 1, in_ready is 0, and op_done and cmd_reject are 0.
- R2: A command seen while cmd_ready is 1 is refused when cmd_len is 0, or when cmd_addr[6:0] + cmd_len is greater than 128. A refused command makes cmd_reject 1 for exactly the next cycle, produces no write strobe, and leaves busy at 0.
- R3: For each byte, chip select is low and write enable is high for exactly SETUP_CYC cycles before write enable falls, with the byte's address and data already on the pins.
- R4: Write enable is low for exactly PULSE_CYC cycles per byte, only while chip select is low, and address and data do not change while it is low.
- R5: After write enable rises, chip select stays low and address and data stay unchanged for exactly HOLD_CYC cycles.
- R6: Byte i of a burst (counting from 0) is written at an address whose bits above bit 6 equal those of cmd_addr and whose bits 6:0 equal cmd_addr[6:0] + i. The byte is the i-th one accepted on the stream.
- R7: in_ready is 1 only while the block is waiting for the next byte. Each in_valid/in_ready handshake loads exactly one byte, and in_ready is 0 in the cycle after a handshake.
- R8: After the last byte's write enable rises, op_done is 1 for one cycle exactly HOLD_CYC + PROG_CYC cycles later. At that point op_underrun is 0 and busy returns to 0.
- R9: Once a burst has loaded at least one byte, if no byte arrives within GAP_CYC cycles of waiting, the burst ends. op_done then comes HOLD_CYC + GAP_CYC + PROG_CYC cycles after the last write enable rise, with op_underrun at 1.
- R10: ee_oe_n is 1 at all times.
- R11: While busy is 1, cmd_ready is 0 and cmd_valid has no effect: no cmd_reject, and the running burst is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | ADDR_W | Start address of the burst |
| cmd_len | input | OFS_W+1 | Byte count, 1 to 128 |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Block takes a byte this cycle |
| in_data | input | DATA_W | Data byte |
| ee_addr | output | ADDR_W | Device address pins |
| ee_data | output | DATA_W | Device data pins (write direction) |
| ee_cs_n | output | 1 | Chip select, active low |
| ee_we_n | output | 1 | Write enable, active low |
| ee_oe_n | output | 1 | Output enable, held inactive |
| busy | output | 1 | Burst or programming wait in progress |
| cmd_reject | output | 1 | One-cycle pulse for a refused command |
| op_done | output | 1 | One-cycle pulse when the operation ends |
| op_underrun | output | 1 | Last operation ended by a stream stall; valid with op_done |

## Verification
A handshake at a clock edge puts the byte on the pins in the next cycle. Chip select then stays low for SETUP_CYC cycles, write enable is low for PULSE_CYC cycles, and HOLD_CYC hold cycles follow. op_done arrives HOLD_CYC + PROG_CYC cycles after the last rise of write enable, or HOLD_CYC + GAP_CYC + PROG_CYC cycles after it when the burst ends on a stall. cmd_reject appears in the cycle right after the refused command. The bench samples every output on the falling clock edge. A pin monitor measures each phase length by counting falling edges from the edge where that phase began, and compares the count with these figures. Addresses and data are recorded at each fall of write enable and compared with values computed from the command.

// File: rtl/epw_pkg.sv
package epw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_PROG
    } epw_state_e;

    function automatic int unsigned max_of3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // A burst must hold at least one byte and must not run past the page end.
    function automatic logic burst_fits(input int unsigned ofs,
                                        input int unsigned len,
                                        input int unsigned page);
        return (len != 0) && (ofs + len <= page);
    endfunction

endpackage

// File: rtl/epw_phase_timer.sv
module epw_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R3: an expired phase stays expired until a new phase is loaded
    a_r3_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);
endmodule

// File: rtl/epw_addr_gen.sv
module epw_addr_gen #(
    parameter int ADDR_W = 17,
    parameter int OFS_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam int PG_W = ADDR_W - OFS_W;

    logic [PG_W-1:0]  page_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            ofs_q  <= '0;
        end else if (load) begin
            page_q <= base[ADDR_W-1:OFS_W];
            ofs_q  <= base[OFS_W-1:0];
        end else if (step) begin
            ofs_q  <= ofs_q + 1'b1;
        end
    end

    assign addr = {page_q, ofs_q};

    // R6: upper address bits only change when a new burst is loaded
    a_r6_page_held: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(page_q));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import epw_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 7,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 32,
    parameter int HOLD_CYC  = 2,
    parameter int GAP_CYC   = 12000,
    parameter int PROG_CYC  = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [OFS_W:0]    cmd_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] ee_addr,
    output logic [DATA_W-1:0] ee_data,
    output logic              ee_cs_n,
    output logic              ee_we_n,
    output logic              ee_oe_n,
    output logic              busy,
    output logic              cmd_reject,
    output logic              op_done,
    output logic              op_underrun
);
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int LONGEST    = max_of3(max_of3(SETUP_CYC, PULSE_CYC, HOLD_CYC),
                                        GAP_CYC, PROG_CYC);
    localparam int CNT_W      = $clog2(LONGEST + 1);

    epw_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic [OFS_W:0]    left_q;
    logic              first_q, under_q, done_q, rej_q;
    logic              t_load, t_zero;
    logic [CNT_W-1:0]  t_val;
    logic              a_load, a_step;
    logic              cmd_ok, take_byte, stall_out, last_byte;

    assign cmd_ok    = burst_fits(int'(cmd_addr[OFS_W-1:0]), int'(cmd_len), PAGE_BYTES);
    assign take_byte = (state_q == ST_WAIT) && in_valid;
    assign stall_out = (state_q == ST_WAIT) && !in_valid && !first_q && t_zero;
    assign last_byte = (left_q == {{OFS_W{1'b0}}, 1'b1});

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        a_load  = 1'b0;
        a_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (cmd_valid && cmd_ok) begin
                state_d = ST_WAIT;
                a_load  = 1'b1;
            end
            ST_WAIT: if (take_byte) begin
                state_d = ST_SETUP;
                t_load  = 1'b1;
                t_val   = CNT_W'(SETUP_CYC - 1);
            end else if (stall_out) begin
                state_d = ST_PROG;
                t_load  = 1'b1;
                t_val   = CNT_W'(PROG_CYC - 1);
            end
            ST_SETUP: if (t_zero) begin
                state_d = ST_STROBE;
                t_load  = 1'b1;
                t_val   = CNT_W'(PULSE_CYC - 1);
            end
            ST_STROBE: if (t_zero) begin
                state_d = ST_HOLD;
                t_load  = 1'b1;
                t_val   = CNT_W'(HOLD_CYC - 1);
            end
            ST_HOLD: if (t_zero) begin
                a_step  = 1'b1;
                t_load  = 1'b1;
                if (last_byte) begin
                    state_d = ST_PROG;
                    t_val   = CNT_W'(PROG_CYC - 1);
                end else begin
                    state_d = ST_WAIT;
                    t_val   = CNT_W'(GAP_CYC - 1);
                end
            end
            ST_PROG: if (t_zero) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            left_q  <= '0;
            first_q <= 1'b0;
            under_q <= 1'b0;
            done_q  <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_PROG) && t_zero;
            rej_q   <= (state_q == ST_IDLE) && cmd_valid && !cmd_ok;
            if (a_load) begin
                left_q  <= cmd_len;
                first_q <= 1'b1;
                under_q <= 1'b0;
            end
            if (take_byte) data_q <= in_data;
            if (stall_out) under_q <= 1'b1;
            if (a_step) begin
                left_q  <= left_q - 1'b1;
                first_q <= 1'b0;
            end
        end
    end

    epw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    epw_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk(clk), .rst(rst), .load(a_load), .base(cmd_addr),
        .step(a_step), .addr(ee_addr)
    );

    assign ee_data     = data_q;
    assign ee_we_n     = (state_q != ST_STROBE);
    assign ee_cs_n     = !((state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                           (state_q == ST_HOLD));
    assign ee_oe_n     = 1'b1;
    assign busy        = (state_q != ST_IDLE);
    assign cmd_ready   = (state_q == ST_IDLE);
    assign in_ready    = (state_q == ST_WAIT);
    assign cmd_reject  = rej_q;
    assign op_done     = done_q;
    assign op_underrun = under_q;

    // R4: strobe only under chip select
    a_r4_strobe_selected: assert property (@(posedge clk) disable iff (rst)
        !ee_we_n |-> !ee_cs_n);
    // R4: pins frozen while the strobe is low
    a_r4_pins_frozen: assert property (@(posedge clk) disable iff (rst)
        (!ee_we_n && $past(!ee_we_n)) |-> ($stable(ee_addr) && $stable(ee_data)));
    // R7: no byte handshake while a byte is on the pins
    a_r7_ready_deselected: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> ee_cs_n);
    // R2: refusal only reported while idle
    a_r2_reject_idle: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> !busy);
    // R8: completion returns the block to idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        op_done |-> cmd_ready);
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
    localparam int AW = 17, DW = 8, OW = 7;
    localparam int SU = 2, PW = 4, HD = 2, GP = 6, PG = 20;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0, in_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [OW:0]   cmd_len = '0;
    logic [DW-1:0] in_data = '0;
    logic cmd_ready, in_ready, ee_cs_n, ee_we_n, ee_oe_n, busy;
    logic cmd_reject, op_done, op_underrun;
    logic [AW-1:0] ee_addr;
    logic [DW-1:0] ee_data;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW), .SETUP_CYC(SU),
        .PULSE_CYC(PW), .HOLD_CYC(HD), .GAP_CYC(GP), .PROG_CYC(PG)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .ee_addr(ee_addr),
        .ee_data(ee_data), .ee_cs_n(ee_cs_n), .ee_we_n(ee_we_n),
        .ee_oe_n(ee_oe_n), .busy(busy), .cmd_reject(cmd_reject),
        .op_done(op_done), .op_underrun(op_underrun));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pin monitor: records each strobe and times every phase
    logic [AW-1:0] cap_addr [0:255];
    logic [DW-1:0] cap_data [0:255];
    int n_strobe = 0, su_cnt = 0, pl_cnt = 0, hd_cnt = 0, since_rise = 0;
    int done_gap = -1;
    bit done_err = 1'b0;
    bit pre = 1'b1, post = 1'b0, prev_we = 1'b1, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!ee_oe_n) chk(1'b0, "R10 oe_n", 0, 1);
            if (!ee_we_n && prev_we) begin
                chk(su_cnt == SU, "R3 setup cycles", su_cnt, SU);
                cap_addr[n_strobe[7:0]] = ee_addr;
                cap_data[n_strobe[7:0]] = ee_data;
                pl_cnt = 1; pre = 1'b0;
            end else if (!ee_we_n) begin
                pl_cnt++;
                if (ee_addr != cap_addr[n_strobe[7:0]] || ee_data != cap_data[n_strobe[7:0]])
                    chk(1'b0, "R4 pins moved in strobe", ee_data, cap_data[n_strobe[7:0]]);
            end
            if (ee_we_n && !prev_we) begin
                chk(pl_cnt == PW, "R4 pulse cycles", pl_cnt, PW);
                hd_cnt = 1; post = 1'b1; since_rise = 0;
                n_strobe++;
            end else begin
                since_rise++;
                if (post && !ee_cs_n && ee_we_n) begin
                    hd_cnt++;
                    if (ee_data != cap_data[n_strobe[7:0]-8'd1])
                        chk(1'b0, "R5 data moved in hold", ee_data, cap_data[n_strobe[7:0]-8'd1]);
                end
            end
            if (ee_cs_n && !prev_cs && post) begin
                chk(hd_cnt == HD, "R5 hold cycles", hd_cnt, HD);
                post = 1'b0; pre = 1'b1; su_cnt = 0;
            end
            if (!ee_cs_n && ee_we_n && pre) su_cnt++;
            if (op_done) begin done_gap = since_rise; done_err = op_underrun; end
            prev_we = ee_we_n; prev_cs = ee_cs_n;
        end
    end

    task automatic report_and_end();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report_and_end();
    end

    task automatic issue(input logic [AW-1:0] a, input int len);
        @(negedge clk);
        cmd_addr = a; cmd_len = (OW+1)'(len); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] d, input int idle);
        while (!in_ready) @(negedge clk);
        repeat (idle) @(negedge clk);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready, "R7 ready drops after handshake", in_ready, 0);
    endtask

    task automatic wait_done();
        done_gap = -1;
        while (done_gap < 0) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ee_we_n && ee_cs_n && ee_oe_n, "R1 pins idle", {ee_we_n, ee_cs_n, ee_oe_n}, 7);
        chk(!busy && cmd_ready && !in_ready, "R1 status", {busy, cmd_ready, in_ready}, 2);
        chk(!op_done && !cmd_reject, "R1 pulses", {op_done, cmd_reject}, 0);
    endtask

    task automatic t_burst(input logic [AW-1:0] a, input int len, input int idle,
                           input logic [DW-1:0] seed, input bit poke);
        int base;
        logic [AW-1:0] ea;
        base = n_strobe;
        issue(a, len);
        chk(busy && !cmd_ready, "R11 busy after accept", busy, 1);
        for (int i = 0; i < len; i++) begin
            push(seed + DW'(i * 7), (i == 0) ? 0 : idle);
            if (poke && i == 0) begin
                cmd_addr = '0; cmd_len = '0; cmd_valid = 1'b1;
                @(negedge clk);
                @(negedge clk);
                cmd_valid = 1'b0;
                chk(!cmd_reject && !cmd_ready, "R11 command ignored while busy", cmd_reject, 0);
            end
        end
        wait_done();
        chk(n_strobe - base == len, "R8 strobe count", n_strobe - base, len);
        chk(done_gap == HD + PG, "R8 done delay", done_gap, HD + PG);
        chk(!done_err, "R8 no underrun", done_err, 0);
        for (int i = 0; i < len; i++) begin
            ea = {a[AW-1:OW], OW'(a[OW-1:0] + OW'(i))};
            chk(cap_addr[8'(base + i)] == ea, "R6 byte address", cap_addr[8'(base + i)], ea);
            chk(cap_data[8'(base + i)] == seed + DW'(i * 7), "R6 byte order",
                cap_data[8'(base + i)], seed + DW'(i * 7));
        end
        @(negedge clk);
        chk(!busy && cmd_ready, "R8 idle after done", busy, 0);
    endtask

    task automatic t_reject(input logic [AW-1:0] a, input int len);
        int base;
        base = n_strobe;
        @(negedge clk);
        cmd_addr = a; cmd_len = (OW+1)'(len); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_reject && !busy, "R2 refused command pulses reject", cmd_reject, 1);
        @(negedge clk);
        chk(!cmd_reject, "R2 reject one cycle", cmd_reject, 0);
        repeat (4) @(negedge clk);
        chk(!busy && n_strobe == base, "R2 no write after refusal", n_strobe - base, 0);
    endtask

    task automatic t_underrun();
        issue(17'h0A405, 4);
        push(8'h11, 0);
        push(8'h22, 0);
        wait_done();
        chk(done_gap == HD + GP + PG, "R9 stall done delay", done_gap, HD + GP + PG);
        chk(done_err, "R9 underrun flag", done_err, 1);
        @(negedge clk);
        chk(!busy, "R9 idle after stall", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_burst(17'h1F3A0, 5, 0, 8'h30, 1'b0);
        t_burst(17'h00C10, 6, 3, 8'hA1, 1'b1);
        t_burst(17'h12380, 128, 0, 8'h05, 1'b0);
        t_burst(17'h0777F, 1, 0, 8'hEE, 1'b0);
        t_reject(17'h00078, 9);
        t_reject(17'h00000, 0);
        t_reject(17'h00100, 129);
        t_underrun();
        t_burst(17'h0A400, 2, 5, 8'h77, 1'b0);
        report_and_end();
    end
endmodule